// File: doc/BRIEF.md
# SDRAM Bank Write Timing Guard

This block watches the decoded command stream of an SDRAM controller and keeps a small timing model of every bank. For each command it reports, in the same cycle, whether that command breaks a write-path timing rule and which rule it breaks. For each bank it shows whether the bank is locked by a precharge in progress and whether a new row activation would be accepted now.

The model covers the write path. A WRITE needs the row-to-column delay after activation. An explicit precharge needs the write recovery time after the last data beat. A WRITE issued with address bit 10 high closes the bank by itself. That internal precharge starts once write recovery and the minimum row-active time have both run out. The bank stays locked until the row precharge time has passed. Commands to other banks stay unaffected, so a controller can interleave banks and hide the precharge time. All timings are counted in clock cycles and are fixed by parameters.

Top module: `sdram_write_guard`

## Requirements
- R1: After reset every bank is idle: `act_ok_o` is all ones, `busy_o` is all zeros, and a NOP (command code 0) reports reason 0 with `viol_o` low.
- R2: A READ (code 2) or WRITE (code 3) to an idle bank reports reason 2 ("bank not active").
- R3: A READ or WRITE to an open bank fewer than TRCD cycles after its ACT (code 1) reports reason 3. At exactly TRCD cycles it is legal (reason 0).
- R4: A legal WRITE with `a10_i` high raises `busy_o` and clears `act_ok_o` for that bank from the next cycle.
- R5: After an auto-precharge WRITE in cycle w to a bank activated in cycle a, the internal precharge starts in cycle s = max(w+BL-1+TWR, a+TRAS). `busy_o` stays high up to cycle s+TRP-1, and `act_ok_o` rises in cycle s+TRP.
- R6: Any non-NOP command (ACT, READ, WRITE, PRE code 4, burst stop code 5) to a busy bank reports reason 1. Busy outranks every other reason.
- R7: A PRE to an open bank before cycle w+BL-1+TWR after its last WRITE in cycle w reports reason 4. From that cycle on it is legal.
- R8: A legal PRE in cycle p to an open bank makes the bank busy from p+1, and `act_ok_o` rises in cycle p+TRP.
- R9: While one bank is busy, commands to other banks are judged only on those banks' own state.
- R10: A command that reports a nonzero reason changes no bank state.
- R11: `viol_o` is high exactly when `reason_o` is nonzero. Legal ACT, burst stop and NOP report reason 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE, 5 burst stop |
| bank_i | input | BA_W | Target bank of the command |
| a10_i | input | 1 | Address bit 10; selects auto-precharge on WRITE |
| viol_o | output | 1 | Current command breaks a rule |
| reason_o | output | 3 | 0 none, 1 busy, 2 not active, 3 row-to-column, 4 write recovery |
| busy_o | output | NBANK | Bank locked by a precharge pending or running |
| act_ok_o | output | NBANK | Bank idle; an ACT would be accepted |

## Verification
The bench drives one auto-precharge write where the minimum row-active time sets the precharge start and one where write recovery sets it. A design that took only one of the two limits would free the bank a cycle or more early in one of those cases. It probes the row-to-column and write-recovery limits one cycle before and exactly at their boundary, which exposes off-by-one counters. It also sends rejected WRITE and PRE commands and then checks that the bank kept its state, since a design that let a flagged command through would open or close a bank. It interleaves a second bank during the first bank's lockout, which catches busy logic that leaks across banks.

// File: rtl/sdram_wg_pkg.sv
package sdram_wg_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_TBST = 3'd5
   } cmd_e;

   // Lower number wins when a command could fail more than one rule.
   typedef enum logic [2:0] {
      RSN_NONE = 3'd0,
      RSN_BUSY = 3'd1,
      RSN_IDLE = 3'd2,
      RSN_RCD  = 3'd3,
      RSN_TWR  = 3'd4
   } reason_e;

   typedef enum logic [1:0] {
      BK_IDLE,
      BK_OPEN,
      BK_APEND,
      BK_PRECH
   } bank_st_e;

   typedef struct packed {
      logic idle;
      logic busy;
      logic rcd_met;
      logic wr_met;
   } bank_view_t;

endpackage

// File: rtl/sdram_wg_rules.sv
module sdram_wg_rules
   import sdram_wg_pkg::*;
(
   input  cmd_e       cmd,
   input  bank_view_t view,
   output reason_e    reason
);

   logic is_rw;
   assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);

   always_comb begin
      reason = RSN_NONE;
      if (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_TBST}) begin
         if (view.busy)
            reason = RSN_BUSY;
         else if (is_rw && view.idle)
            reason = RSN_IDLE;
         else if (is_rw && !view.rcd_met)
            reason = RSN_RCD;
         else if (cmd == CMD_PRE && !view.idle && !view.wr_met)
            reason = RSN_TWR;
      end
   end

endmodule

// File: rtl/sdram_wg_bank.sv
module sdram_wg_bank
   import sdram_wg_pkg::*;
#(
   parameter int BL   = 4,
   parameter int TRCD = 2,
   parameter int TRAS = 8,
   parameter int TWR  = 2,
   parameter int TRP  = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  cmd_e       cmd,
   input  logic       a10,
   output bank_view_t view
);

   localparam int RAS_W   = $clog2(TRAS + 1);
   localparam int WR_W    = $clog2(BL + TWR);
   localparam int RP_W    = $clog2(TRP + 1);
   localparam int WR_LOAD = BL + TWR - 2;

   localparam logic [RAS_W-1:0] TRAS_V    = RAS_W'(TRAS);
   localparam logic [RAS_W-1:0] TRCD_V    = RAS_W'(TRCD);
   localparam logic [WR_W-1:0]  WR_LOAD_V = WR_W'(WR_LOAD);
   localparam logic [RP_W-1:0]  RP_LOAD_V = RP_W'(TRP - 1);
   localparam logic [RP_W-1:0]  RP_ONE    = RP_W'(1);

   bank_st_e         st, st_nx, pre_next;
   logic [RAS_W-1:0] ras_age;
   logic [WR_W-1:0]  wr_left;
   logic [RP_W-1:0]  rp_left, rp_nx;
   logic             pre_go;

   // A one-cycle row precharge returns straight to idle; longer ones count.
   generate
      if (TRP == 1) begin : g_rp_short
         assign pre_next = BK_IDLE;
      end else begin : g_rp_long
         assign pre_next = BK_PRECH;
      end
   endgenerate

   always_comb begin
      st_nx  = st;
      rp_nx  = rp_left;
      pre_go = 1'b0;
      unique case (st)
         BK_IDLE: begin
            if (take && cmd == CMD_ACT) st_nx = BK_OPEN;
         end
         BK_OPEN: begin
            if (take && cmd == CMD_WR && a10) st_nx = BK_APEND;
            else if (take && cmd == CMD_PRE)   pre_go = 1'b1;
         end
         BK_APEND: begin
            // both write recovery and minimum row-active time must be done
            if (wr_left == '0 && ras_age == TRAS_V) pre_go = 1'b1;
         end
         BK_PRECH: begin
            if (rp_left <= RP_ONE) st_nx = BK_IDLE;
            else                   rp_nx = rp_left - RP_ONE;
         end
         default: st_nx = BK_IDLE;
      endcase
      if (pre_go) begin
         st_nx = pre_next;
         rp_nx = RP_LOAD_V;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= BK_IDLE;
         ras_age <= '0;
         wr_left <= '0;
         rp_left <= '0;
      end else begin
         st      <= st_nx;
         rp_left <= rp_nx;
         if (take && cmd == CMD_ACT)
            ras_age <= RAS_W'(1);
         else if (ras_age != TRAS_V)
            ras_age <= ras_age + RAS_W'(1);
         if (take && cmd == CMD_WR)
            wr_left <= WR_LOAD_V;
         else if (wr_left != '0)
            wr_left <= wr_left - WR_W'(1);
      end
   end

   assign view.idle    = (st == BK_IDLE);
   assign view.busy    = (st == BK_APEND) || (st == BK_PRECH);
   assign view.rcd_met = (ras_age >= TRCD_V);
   assign view.wr_met  = (wr_left == '0);

endmodule

// File: rtl/sdram_write_guard.sv
module sdram_write_guard
   import sdram_wg_pkg::*;
#(
   parameter  int NBANK = 4,
   parameter  int BL    = 4,
   parameter  int TRCD  = 2,
   parameter  int TRAS  = 8,
   parameter  int TWR   = 2,
   parameter  int TRP   = 2,
   localparam int BA_W  = $clog2(NBANK)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd_i,
   input  logic [BA_W-1:0]  bank_i,
   input  logic             a10_i,
   output logic             viol_o,
   output logic [2:0]       reason_o,
   output logic [NBANK-1:0] busy_o,
   output logic [NBANK-1:0] act_ok_o
);

   generate
      if (!(BL == 1 || BL == 2 || BL == 4 || BL == 8)) begin : g_bad_bl
         $error("burst length must be 1, 2, 4 or 8");
      end
      if (NBANK < 2 || (1 << BA_W) != NBANK) begin : g_bad_nbank
         $error("bank count must be a power of two, at least 2");
      end
      if (TRCD < 1 || TRAS < TRCD) begin : g_bad_ras
         $error("need 1 <= TRCD <= TRAS");
      end
      if (TWR < 1 || TRP < 1) begin : g_bad_wr_rp
         $error("TWR and TRP must be at least 1");
      end
   endgenerate

   cmd_e       cmd;
   reason_e    reason;
   bank_view_t views [NBANK];
   bank_view_t tgt_view;
   logic       accept;

   assign cmd      = cmd_e'(cmd_i);
   assign tgt_view = views[bank_i];

   sdram_wg_rules u_rules (
      .cmd    (cmd),
      .view   (tgt_view),
      .reason (reason)
   );

   assign accept   = (reason == RSN_NONE) && (cmd != CMD_NOP);
   assign viol_o   = (reason != RSN_NONE);
   assign reason_o = reason;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         logic take_b;
         assign take_b = accept && (bank_i == BA_W'(b));

         sdram_wg_bank #(
            .BL   (BL),
            .TRCD (TRCD),
            .TRAS (TRAS),
            .TWR  (TWR),
            .TRP  (TRP)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take_b),
            .cmd   (cmd),
            .a10   (a10_i),
            .view  (views[b])
         );

         assign busy_o[b]   = views[b].busy;
         assign act_ok_o[b] = views[b].idle;
      end
   endgenerate

endmodule

// File: rtl/sdram_wg_checker.sv
module sdram_wg_checker #(
   parameter  int NBANK = 4,
   parameter  int TRP   = 2,
   localparam int BA_W  = $clog2(NBANK)
)(
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cmd_i,
   input logic [BA_W-1:0]  bank_i,
   input logic             a10_i,
   input logic             viol_o,
   input logic [2:0]       reason_o,
   input logic [NBANK-1:0] busy_o,
   input logic [NBANK-1:0] act_ok_o
);

   logic real_cmd;
   assign real_cmd = (cmd_i != 3'd0) && (cmd_i <= 3'd5);

   // R6: a busy bank rejects every real command with the busy code
   a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (real_cmd && busy_o[bank_i]) |-> (reason_o == 3'd1 && viol_o));

   // R2: read or write to an idle bank reports not-active
   a_r2_idle_rw: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_i == 3'd2 || cmd_i == 3'd3) && act_ok_o[bank_i]) |-> (reason_o == 3'd2));

   // R4: accepted auto-precharge write locks the bank next cycle
   a_r4_ap_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd3 && a10_i && !viol_o) |=>
         (busy_o[$past(bank_i)] && !act_ok_o[$past(bank_i)]));

   // R8: accepted precharge of an open bank locks it next cycle
   a_r8_pre_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (TRP > 1 && cmd_i == 3'd4 && !viol_o && !act_ok_o[bank_i]) |=>
         busy_o[$past(bank_i)]);

   // R11: legal activation always reports the clean code
   a_r11_act_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd1 && !busy_o[bank_i]) |-> (reason_o == 3'd0 && !viol_o));

   // R5: a bank is never both locked and ready for activation
   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_excl
         a_r5_busy_vs_ready: assert property (@(posedge clk) disable iff (!rst_n)
            !(busy_o[b] && act_ok_o[b]));
      end
   endgenerate

endmodule

bind sdram_write_guard sdram_wg_checker #(
   .NBANK (NBANK),
   .TRP   (TRP)
) u_wg_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_i    (cmd_i),
   .bank_i   (bank_i),
   .a10_i    (a10_i),
   .viol_o   (viol_o),
   .reason_o (reason_o),
   .busy_o   (busy_o),
   .act_ok_o (act_ok_o)
);

// File: tb/sdram_write_guard_tb.sv
module sdram_write_guard_tb_top;

   localparam int NBANK = 4;
   localparam int BL    = 4;
   localparam int TRCD  = 2;
   localparam int TRAS  = 8;
   localparam int TWR   = 2;
   localparam int TRP   = 2;

   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                          PRE = 3'd4, TBST = 3'd5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       cmd_i = NOP;
   logic [1:0]       bank_i = '0;
   logic             a10_i = 1'b0;
   logic             viol_o;
   logic [2:0]       reason_o;
   logic [NBANK-1:0] busy_o;
   logic [NBANK-1:0] act_ok_o;

   int checks = 0;
   int fails  = 0;
   int cnum   = 0;

   typedef struct {
      logic [2:0] code;
      string      tag;
   } exp_t;
   exp_t sb_q[$];
   exp_t item;

   always #5 clk = ~clk;

   sdram_write_guard #(
      .NBANK (NBANK), .BL (BL), .TRCD (TRCD), .TRAS (TRAS), .TWR (TWR), .TRP (TRP)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cmd_i (cmd_i), .bank_i (bank_i), .a10_i (a10_i),
      .viol_o (viol_o), .reason_o (reason_o), .busy_o (busy_o), .act_ok_o (act_ok_o)
   );

   function automatic int max2(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // driver: presents one command for one cycle and queues its expected code
   task automatic cyc(input logic [2:0] c, input int b, input logic a,
                      input logic [2:0] e, input string tag);
      @(negedge clk);
      cnum++;
      cmd_i  = c;
      bank_i = b[1:0];
      a10_i  = a;
      sb_q.push_back('{e, tag});
      #3;
   endtask

   task automatic st_chk(input int b, input logic eb, input logic ea, input string tag);
      chk(busy_o[b] == eb, {tag, " busy"}, int'(busy_o[b]), int'(eb));
      chk(act_ok_o[b] == ea, {tag, " act_ok"}, int'(act_ok_o[b]), int'(ea));
   endtask

   task automatic wait_free(input int b, input int rel, input string tag);
      while (cnum < rel) begin
         cyc(NOP, 0, 1'b0, 3'd0, tag);
         st_chk(b, cnum < rel, cnum >= rel, tag);
      end
   endtask

   // monitor: compares the reported code just before the sampling edge
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (sb_q.size() > 0) begin
            item = sb_q.pop_front();
            chk(reason_o == item.code, {item.tag, " reason"}, int'(reason_o), int'(item.code));
            chk(viol_o == (item.code != 3'd0), {item.tag, " viol R11"},
                int'(viol_o), int'(item.code != 3'd0));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int a0, w0, a1, w1, p1, a3, w3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cyc(NOP, 0, 1'b0, 3'd0, "R1 nop");
      for (int b = 0; b < NBANK; b++) st_chk(b, 1'b0, 1'b1, "R1 reset");

      // bank 0: write with auto-precharge, row-active time dominates
      cyc(ACT, 0, 1'b0, 3'd0, "R11 act"); a0 = cnum;
      cyc(WR, 0, 1'b0, 3'd3, "R3 early write");
      cyc(WR, 0, 1'b1, 3'd0, "R3 write at tRCD"); w0 = cnum;
      st_chk(0, 1'b0, 1'b0, "R4 open before lock");
      cyc(RD, 0, 1'b0, 3'd1, "R6 read busy");
      st_chk(0, 1'b1, 1'b0, "R4 locked");
      cyc(ACT, 1, 1'b0, 3'd0, "R9 act other bank"); a1 = cnum;
      cyc(PRE, 0, 1'b0, 3'd1, "R6 pre busy");
      cyc(RD, 1, 1'b0, 3'd0, "R9 read other bank at tRCD");
      cyc(WR, 1, 1'b0, 3'd0, "R9 write other bank"); w1 = cnum;
      wait_free(0, max2(w0 + BL - 1 + TWR, a0 + TRAS) + TRP, "R5 tRAS-bound");

      // bank 1: explicit precharge after write recovery
      cyc(PRE, 1, 1'b0, (cnum + 1 >= w1 + BL - 1 + TWR) ? 3'd0 : 3'd4, "R7 early pre");
      cyc(PRE, 1, 1'b0, 3'd0, "R7 pre at tWR"); p1 = cnum;
      st_chk(1, 1'b0, 1'b0, "R10 rejected pre kept bank open");
      cyc(WR, 1, 1'b0, 3'd1, "R6 write during precharge");
      st_chk(1, 1'b1, 1'b0, "R8 locked");
      wait_free(1, p1 + TRP, "R8 release");

      // bank 2: idle bank accesses
      cyc(WR, 2, 1'b1, 3'd2, "R2 write idle");
      cyc(NOP, 2, 1'b0, 3'd0, "R10 nop");
      st_chk(2, 1'b0, 1'b1, "R10 rejected write left bank idle");
      cyc(RD, 2, 1'b0, 3'd2, "R2 read idle");
      cyc(TBST, 2, 1'b0, 3'd0, "R11 burst stop idle");

      // bank 3: write recovery dominates
      cyc(ACT, 3, 1'b0, 3'd0, "R11 act b3"); a3 = cnum;
      cyc(NOP, 0, 1'b0, 3'd0, "R11 nop");
      cyc(NOP, 0, 1'b0, 3'd0, "R11 nop");
      cyc(NOP, 0, 1'b0, 3'd0, "R11 nop");
      cyc(WR, 3, 1'b1, 3'd0, "R4 late ap write"); w3 = cnum;
      cyc(TBST, 3, 1'b0, 3'd1, "R6 burst stop busy");
      cyc(ACT, 3, 1'b0, 3'd1, "R6 act busy");
      wait_free(3, max2(w3 + BL - 1 + TWR, a3 + TRAS) + TRP, "R5 tWR-bound");

      cyc(ACT, 0, 1'b0, 3'd0, "R5 reopen bank0");
      cyc(NOP, 0, 1'b0, 3'd0, "R11 nop");
      st_chk(0, 1'b0, 1'b0, "R5 bank0 open");

      cmd_i = NOP;
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule